// File: doc/BRIEF.md
# Partial Transfer Report Queue

This block keeps a short record of transfers that stopped before their programmed length. One example is a streaming source that raises its end marker early. Each record holds the transfer's identifier and the number of bytes that were actually moved. The records sit in a small first-in first-out store until software collects them.

Each request is submitted with a report-enable bit, and the block remembers that bit per identifier. When a completion event arrives, a record is made only if the event is marked early and the enable bit for its identifier is set. Software empties the store in a loop:

1. Read the byte count.
2. Read the identifier. This read removes the record.
3. Read the completion word and test its top bit.
4. Repeat while that bit is set.

If a record arrives while the store is full, the record is lost and a sticky status bit is set.

Top module: `partial_report_queue`

## Requirements
- R1: After reset the store is empty. `moreReports` is 0, and reads of the length (0x44C), identifier (0x450), completion word (0x428) and status (0x430) offsets all return 0.
- R2: An early completion is recorded only if the most recent submission of its identifier had `reqReport` set to 1. Otherwise it leaves the store unchanged.
- R3: A completion with `doneEarly` low is never recorded.
- R4: A read of offset 0x44C returns the oldest record's byte count, zero-extended, and leaves the store unchanged.
- R5: A read of offset 0x450 returns the oldest record's identifier, zero-extended in bits 4:0, and removes that record.
- R6: A read of offset 0x428 returns bit 31 set to 1 when at least one record was stored at the read cycle. All other bits read 0.
- R7: Records are read back in the order their completions arrived.
- R8: The store holds DEPTH (default 4) records. A record that arrives while the store is full, with no removal in the same cycle, is dropped. It also sets bit 0 of the status word at 0x430, which stays set until reset.
- R9: Reads of 0x44C or 0x450 while the store is empty return 0 and remove nothing.
- R10: A record that arrives while the store is full, in the same cycle as an identifier read, is kept. The status bit is not set.
- R11: The output `moreReports` is 1 exactly when at least one record is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request submission strobe |
| reqId | input | ID_W (5) | Identifier of the submitted request |
| reqReport | input | 1 | Early-termination reporting enabled for this request |
| doneValid | input | 1 | Completion event strobe |
| doneId | input | ID_W (5) | Identifier of the completed transfer |
| doneBytes | input | LEN_W (24) | Bytes actually moved by the completed transfer |
| doneEarly | input | 1 | Transfer ended before its programmed length |
| rdEn | input | 1 | Register read strobe |
| rdAddr | input | ADDR_W (12) | Register read offset |
| rdData | output | DATA_W (32) | Read data, valid from the clock edge after the strobe |
| moreReports | output | 1 | At least one record waits to be read |

## Verification
The hardest situation to reach is a full store that gets a new early completion and an identifier read in the same cycle. In that case a correct design keeps the new record, and an off-by-one in the full test would drop it. The bench first fills the store to its depth. It then issues a completion and an identifier read from the same clock-low phase, so both land on one edge. Draining then shows whether the last record survived and whether the status bit stayed clear. Overflow is then provoked separately, with no removal in that cycle, to confirm the drop and the sticky bit.

// File: rtl/prq_pkg.sv
package prq_pkg;

  // Register offsets decoded by the read port
  localparam logic [11:0] OFS_DONE_WORD = 12'h428;
  localparam logic [11:0] OFS_STATUS    = 12'h430;
  localparam logic [11:0] OFS_PART_LEN  = 12'h44C;
  localparam logic [11:0] OFS_PART_ID   = 12'h450;

  // Bit of the completion word that flags pending records
  localparam int MORE_BIT = 31;
  // Bit of the status word holding the sticky overflow
  localparam int OVFL_BIT = 0;

  // Strobes from control to storage
  typedef struct packed {
    logic push;
    logic pop;
  } prq_strobe_t;

endpackage

// File: rtl/prq_store.sv
module prq_store
  import prq_pkg::*;
#(
  parameter int ID_W  = 5,
  parameter int LEN_W = 24,
  parameter int DEPTH = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  prq_strobe_t                       strb,
  input  logic [ID_W-1:0]                   wrId,
  input  logic [LEN_W-1:0]                  wrLen,
  output logic [ID_W-1:0]                   headId,
  output logic [LEN_W-1:0]                  headLen,
  output logic [$clog2(DEPTH+1)-1:0]        count,
  output logic                              full,
  output logic                              empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [ID_W-1:0]  idView  [DEPTH];
  logic [LEN_W-1:0] lenView [DEPTH];

  function automatic logic [PTR_W-1:0] stepPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [ID_W-1:0]  slotId;
    logic [LEN_W-1:0] slotLen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotId  <= '0;
        slotLen <= '0;
      end else if (strb.push && wrPtr == PTR_W'(g)) begin
        slotId  <= wrId;
        slotLen <= wrLen;
      end
    end
    assign idView[g]  = slotId;
    assign lenView[g] = slotLen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= stepPtr(wrPtr);
      if (strb.pop)  rdPtr <= stepPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headId  = idView[rdPtr];
  assign headLen = lenView[rdPtr];
  assign empty   = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));

endmodule

// File: rtl/prq_ctrl.sv
module prq_ctrl
  import prq_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int LEN_W  = 24,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqReport,
  input  logic              doneValid,
  input  logic [ID_W-1:0]   doneId,
  input  logic              doneEarly,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ID_W-1:0]   headId,
  input  logic [LEN_W-1:0]  headLen,
  input  logic              full,
  input  logic              empty,
  output prq_strobe_t       strb,
  output logic [DATA_W-1:0] rdData,
  output logic              ovflSticky
);

  localparam int NUM_ID = 1 << ID_W;

  logic [NUM_ID-1:0] reportEn;
  logic              recordReq;
  logic              popReq;
  logic [DATA_W-1:0] readMux;

  // Per-identifier report enable, latched at submission
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         reportEn <= '0;
    else if (reqValid) reportEn[reqId] <= reqReport;
  end

  assign recordReq = doneValid && doneEarly && reportEn[doneId];
  assign popReq    = rdEn && (rdAddr == ADDR_W'(OFS_PART_ID)) && !empty;

  // A slot freed in the same cycle makes room for the new record
  assign strb.pop  = popReq;
  assign strb.push = recordReq && (!full || popReq);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               ovflSticky <= 1'b0;
    else if (recordReq && full && !popReq)   ovflSticky <= 1'b1;
  end

  always_comb begin
    readMux = '0;
    if (rdAddr == ADDR_W'(OFS_DONE_WORD)) begin
      readMux[MORE_BIT] = !empty;
    end else if (rdAddr == ADDR_W'(OFS_STATUS)) begin
      readMux[OVFL_BIT] = ovflSticky;
    end else if (rdAddr == ADDR_W'(OFS_PART_LEN)) begin
      if (!empty) readMux = DATA_W'(headLen);
    end else if (rdAddr == ADDR_W'(OFS_PART_ID)) begin
      if (!empty) readMux = DATA_W'(headId);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= readMux;
  end

endmodule

// File: rtl/partial_report_queue.sv
module partial_report_queue
  import prq_pkg::*;
#(
  parameter int ID_W   = 5,
  parameter int LEN_W  = 24,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ID_W-1:0]   reqId,
  input  logic              reqReport,
  input  logic              doneValid,
  input  logic [ID_W-1:0]   doneId,
  input  logic [LEN_W-1:0]  doneBytes,
  input  logic              doneEarly,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              moreReports
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  prq_strobe_t       strb;
  logic [ID_W-1:0]   headId;
  logic [LEN_W-1:0]  headLen;
  logic [CNT_W-1:0]  fillCount;
  logic              full, empty, ovflSticky;

  prq_ctrl #(
    .ID_W(ID_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqId(reqId), .reqReport(reqReport),
    .doneValid(doneValid), .doneId(doneId), .doneEarly(doneEarly),
    .rdEn(rdEn), .rdAddr(rdAddr),
    .headId(headId), .headLen(headLen), .full(full), .empty(empty),
    .strb(strb), .rdData(rdData), .ovflSticky(ovflSticky)
  );

  prq_store #(
    .ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH)
  ) uStore (
    .clk(clk), .rstN(rstN), .strb(strb),
    .wrId(doneId), .wrLen(doneBytes),
    .headId(headId), .headLen(headLen),
    .count(fillCount), .full(full), .empty(empty)
  );

  assign moreReports = !empty;

endmodule

// File: rtl/partial_report_queue_chk.sv
module partial_report_queue_chk
  import prq_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              doneValid,
  input logic              doneEarly,
  input logic              rdEn,
  input logic [ADDR_W-1:0] rdAddr,
  input logic [DATA_W-1:0] rdData,
  input logic              moreReports,
  input logic [CNT_W-1:0]  fillCount,
  input logic              ovflSticky
);

  a_r8_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CNT_W'(DEPTH));

  a_r8_ovfl_sticky: assert property (@(posedge clk) disable iff (!rstN)
    ovflSticky |=> ovflSticky);

  a_r3_no_growth_without_early: assert property (@(posedge clk) disable iff (!rstN)
    !(doneValid && doneEarly) |=> fillCount <= $past(fillCount));

  a_r4_len_read_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_W'(OFS_PART_LEN) && !(doneValid && doneEarly))
      |=> fillCount == $past(fillCount));

  a_r9_empty_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !moreReports &&
     (rdAddr == ADDR_W'(OFS_PART_LEN) || rdAddr == ADDR_W'(OFS_PART_ID)))
      |=> rdData == '0);

  a_r6_done_flag: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdAddr == ADDR_W'(OFS_DONE_WORD))
      |=> rdData[MORE_BIT] == $past(moreReports));

endmodule

bind partial_report_queue partial_report_queue_chk #(
  .CNT_W(CNT_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .doneValid(doneValid), .doneEarly(doneEarly),
  .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .moreReports(moreReports),
  .fillCount(fillCount), .ovflSticky(ovflSticky)
);

// File: tb/partial_report_queue_test.sv
module partial_report_queue_test;

  localparam logic [11:0] A_DONE = 12'h428;
  localparam logic [11:0] A_STAT = 12'h430;
  localparam logic [11:0] A_LEN  = 12'h44C;
  localparam logic [11:0] A_ID   = 12'h450;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqReport = 1'b0;
  logic [4:0]  reqId = '0, doneId = '0;
  logic        doneValid = 1'b0, doneEarly = 1'b0;
  logic [23:0] doneBytes = '0;
  logic        rdEn = 1'b0;
  logic [11:0] rdAddr = '0;
  logic [31:0] rdData;
  logic        moreReports;

  int total = 0, fails = 0;
  bit enTab [32];
  int qId [$];
  int qLen [$];
  bit finished = 0;

  always #5 clk = ~clk;

  partial_report_queue uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqId(reqId),
    .reqReport(reqReport), .doneValid(doneValid), .doneId(doneId),
    .doneBytes(doneBytes), .doneEarly(doneEarly), .rdEn(rdEn),
    .rdAddr(rdAddr), .rdData(rdData), .moreReports(moreReports)
  );

  task automatic check(input string req, input longint got, input longint exp);
    total++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic submit(input int id, input bit rep);
    @(negedge clk);
    reqValid = 1'b1; reqId = 5'(id); reqReport = rep;
    @(negedge clk);
    reqValid = 1'b0;
    enTab[id] = rep;
  endtask

  // Driver: applies a completion and pushes the expected record
  task automatic complete(input int id, input int bytes, input bit early);
    @(negedge clk);
    doneValid = 1'b1; doneId = 5'(id); doneBytes = 24'(bytes); doneEarly = early;
    @(negedge clk);
    doneValid = 1'b0; doneEarly = 1'b0;
    if (early && enTab[id] && qId.size() < 4) begin
      qId.push_back(id); qLen.push_back(bytes);
    end
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = a;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  // Monitor: drains one record the way software does and compares it
  task automatic drainOne(input string req);
    logic [31:0] l, i, w;
    int eId, eLen;
    eId = qId.pop_front(); eLen = qLen.pop_front();
    rd(A_LEN, l);
    rd(A_ID, i);
    rd(A_DONE, w);
    check({req, " length"}, l, eLen);
    check({req, " id"}, i, eId);
    check({req, " more flag"}, w, (qId.size() != 0) ? 32'h8000_0000 : 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    check("R1 moreReports", moreReports, 0);
    rd(A_LEN, d);  check("R1 length reg", d, 0);
    rd(A_ID, d);   check("R1 id reg", d, 0);
    rd(A_DONE, d); check("R1 done word", d, 0);
    rd(A_STAT, d); check("R1 status", d, 0);

    submit(3, 1); submit(5, 0); submit(7, 1);

    // R2: report enable not set -> nothing stored
    complete(5, 77, 1);
    check("R2 disabled id ignored", moreReports, 0);
    rd(A_LEN, d); check("R2 length after disabled", d, 0);
    // R3: normal completion is not a record
    complete(3, 99, 0);
    check("R3 full-length ignored", moreReports, 0);

    complete(3, 100, 1);
    complete(7, 200, 1);
    // R11: flag follows the store
    check("R11 moreReports set", moreReports, 1);
    // R4: length read has no side effect
    rd(A_LEN, d); check("R4 length first read", d, 100);
    rd(A_LEN, d); check("R4 length repeat read", d, 100);
    // R6: completion word flag
    rd(A_DONE, d); check("R6 done word pending", d, 32'h8000_0000);
    // R5: id read pops
    rd(A_ID, d);  check("R5 id pop", d, 3);
    void'(qId.pop_front()); void'(qLen.pop_front());
    drainOne("R7 second record");
    check("R11 moreReports cleared", moreReports, 0);

    // R9: empty reads
    rd(A_ID, d);  check("R9 empty id read", d, 0);
    rd(A_LEN, d); check("R9 empty length read", d, 0);
    check("R9 still empty", moreReports, 0);

    // R10: full store, push and pop in one cycle
    complete(3, 10, 1); complete(7, 20, 1); complete(3, 30, 1); complete(7, 40, 1);
    @(negedge clk);
    doneValid = 1'b1; doneId = 5'd7; doneBytes = 24'd50; doneEarly = 1'b1;
    rdEn = 1'b1; rdAddr = A_ID;
    @(negedge clk);
    doneValid = 1'b0; doneEarly = 1'b0; rdEn = 1'b0;
    check("R10 popped head id", rdData, 3);
    void'(qId.pop_front()); void'(qLen.pop_front());
    qId.push_back(7); qLen.push_back(50);
    rd(A_STAT, d); check("R10 no overflow", d, 0);
    // R7: order preserved through wrap
    drainOne("R7 order a"); drainOne("R7 order b");
    drainOne("R7 order c"); drainOne("R10 kept record");

    // R8: overflow drops and sticks
    complete(3, 11, 1); complete(3, 12, 1); complete(7, 13, 1); complete(7, 14, 1);
    complete(3, 15, 1);
    rd(A_STAT, d); check("R8 overflow bit", d, 1);
    drainOne("R8 keep 1"); drainOne("R8 keep 2");
    drainOne("R8 keep 3"); drainOne("R8 keep 4");
    check("R8 dropped record absent", moreReports, 0);
    rd(A_STAT, d); check("R8 overflow sticky", d, 1);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule